// File: doc/BRIEF.md
# Sliding-Window Deglitch Filter with Hysteresis

This block cleans up a noisy single-bit signal that has already been brought into the local clock domain. On each cycle where the sample strobe is high, it takes one input sample and keeps a running count of how many ones sit among the most recent `WIN_LEN` samples. A shift register remembers each sample until it leaves the window. The count goes up by one for each incoming one and down by one for each one that drops out of the far end of the window. Each update is therefore a single add-and-subtract, whatever the window length.

A two-state machine turns the count into the filtered output. The states are `FLT_LOW` (output 0) and `FLT_HIGH` (output 1). The *rise* transition from `FLT_LOW` to `FLT_HIGH` fires when the count is strictly above `HI_THR`. The *fall* transition from `FLT_HIGH` to `FLT_LOW` fires when the count is strictly below `LO_THR`. In every other case the state stays where it is. This gap between the two thresholds is the hysteresis that stops the output from chattering on a signal that sits near a single threshold.

A longer window removes wider glitches, but a real edge then takes longer to reach the output. The state register samples the count one clock after the count updates, so the output trails the count by one cycle.

Top module: `deglitch_window`

## Requirements
- R1: A synchronous, active-high `rst` empties the window (count 0, every stored sample 0) and forces the state to `FLT_LOW`, so `dout` is 0 on the cycle after any clock edge with `rst` high.
- R2: After each clock edge with `smp_en` high, the count equals the number of ones among the last `WIN_LEN` accepted samples. Sample positions not yet filled since reset count as 0.
- R3: The state machine evaluates the count held before each clock edge. From `FLT_LOW`, a count greater than `HI_THR` moves the state to `FLT_HIGH` at that edge, so `dout` = 1. A count exactly equal to `HI_THR` does not.
- R4: From `FLT_HIGH`, a count less than `LO_THR` moves the state to `FLT_LOW`, so `dout` = 0. A count exactly equal to `LO_THR` does not.
- R5: While the count lies in `[LO_THR, HI_THR]`, `dout` keeps its previous value.
- R6: On a clock edge with `smp_en` low, `din` is ignored: the count and the stored samples do not change.
- R7: The count stays within 0..`WIN_LEN` and never wraps. Its width is `$clog2(WIN_LEN+1)` bits.
- R8: The parameters must satisfy `LO_THR < HI_THR <= WIN_LEN`. This is checked at elaboration.
- R9: Starting from an empty window, a burst of at most `HI_THR` ones never raises `dout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_en | input | 1 | Sample strobe; the window advances only when high |
| din | input | 1 | Synchronized noisy input bit |
| dout | output | 1 | Filtered output (1 in `FLT_HIGH`) |

## Verification
The assertions assume that `din` and `smp_en` are already synchronous to `clk` and settled before each edge. They also assume that `rst` is held for at least one edge before filtering starts, so the count, the delay line and the state begin from a known empty window. The stimulus changes inputs only on the falling clock edge and opens every scenario with a reset. It uses windows of ones, zeros and mixed runs so that the count sweeps the exact threshold values from both directions. It also includes long stretches with the strobe low while `din` moves, so that R6 is exercised with input changes that must not be taken in.

// File: rtl/deglitch_pkg.sv
package deglitch_pkg;

    typedef enum logic {
        FLT_LOW  = 1'b0,
        FLT_HIGH = 1'b1
    } flt_state_e;

endpackage

// File: rtl/deglitch_delay.sv
module deglitch_delay #(
    parameter int WIN_LEN = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic adv,
    input  logic bit_in,
    output logic bit_tail
);

    logic [WIN_LEN-1:0] stage_q;

    generate
        for (genvar g = 0; g < WIN_LEN; g++) begin : g_stage
            if (g == 0) begin : g_head
                always_ff @(posedge clk) begin
                    if (rst)
                        stage_q[0] <= 1'b0;
                    else if (adv)
                        stage_q[0] <= bit_in;
                end
            end else begin : g_body
                always_ff @(posedge clk) begin
                    if (rst)
                        stage_q[g] <= 1'b0;
                    else if (adv)
                        stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign bit_tail = stage_q[WIN_LEN-1];

    // R6
    delay_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(stage_q));

endmodule

// File: rtl/deglitch_accum.sv
module deglitch_accum #(
    parameter int WIN_LEN = 8,
    localparam int CNT_W  = $clog2(WIN_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    input  logic             bit_in,
    input  logic             bit_tail,
    output logic [CNT_W-1:0] ones_cnt
);

    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WIN_LEN);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        unique case ({bit_in, bit_tail})
            2'b10:   cnt_d = cnt_q + 1'b1;
            2'b01:   cnt_d = cnt_q - 1'b1;
            default: cnt_d = cnt_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (adv)
            cnt_q <= cnt_d;
    end

    assign ones_cnt = cnt_q;

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_MAX);

    // R7
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && bit_tail && !bit_in) |-> (cnt_q != '0));

    // R6
    cnt_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(cnt_q));

    // R2
    cnt_step_up_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && bit_in && !bit_tail) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/deglitch_hyst_fsm.sv
module deglitch_hyst_fsm
    import deglitch_pkg::*;
#(
    parameter int WIN_LEN = 8,
    parameter int HI_THR  = 6,
    parameter int LO_THR  = 2,
    localparam int CNT_W  = $clog2(WIN_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] ones_cnt,
    output logic             level
);

    localparam logic [CNT_W-1:0] HI_C = CNT_W'(HI_THR);
    localparam logic [CNT_W-1:0] LO_C = CNT_W'(LO_THR);

    flt_state_e state_q;
    flt_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLT_LOW:  if (ones_cnt > HI_C) state_d = FLT_HIGH;
            FLT_HIGH: if (ones_cnt < LO_C) state_d = FLT_LOW;
            default:  state_d = FLT_LOW;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= FLT_LOW;
        else
            state_q <= state_d;
    end

    always_comb begin
        level = (state_q == FLT_HIGH);
    end

    // R1
    reset_low_chk: assert property (@(posedge clk)
        rst |=> (!level && ones_cnt == '0));

    // R3
    rise_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == FLT_LOW && ones_cnt > HI_C) |=> level);

    // R4
    fall_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == FLT_HIGH && ones_cnt < LO_C) |=> !level);

    // R5
    hold_band_chk: assert property (@(posedge clk) disable iff (rst)
        (ones_cnt >= LO_C && ones_cnt <= HI_C) |=> $stable(level));

endmodule

// File: rtl/deglitch_window.sv
module deglitch_window #(
    parameter int WIN_LEN = 8,
    parameter int HI_THR  = 6,
    parameter int LO_THR  = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic smp_en,
    input  logic din,
    output logic dout
);

    localparam int CNT_W = $clog2(WIN_LEN + 1);

    // R8
    initial begin
        param_legal_chk: assert (LO_THR < HI_THR && HI_THR <= WIN_LEN && LO_THR >= 0)
            else $error("deglitch_window: need LO_THR < HI_THR <= WIN_LEN");
    end

    logic             tail_bit;
    logic [CNT_W-1:0] ones_cnt;

    deglitch_delay #(
        .WIN_LEN (WIN_LEN)
    ) u_delay (
        .clk      (clk),
        .rst      (rst),
        .adv      (smp_en),
        .bit_in   (din),
        .bit_tail (tail_bit)
    );

    deglitch_accum #(
        .WIN_LEN (WIN_LEN)
    ) u_accum (
        .clk      (clk),
        .rst      (rst),
        .adv      (smp_en),
        .bit_in   (din),
        .bit_tail (tail_bit),
        .ones_cnt (ones_cnt)
    );

    deglitch_hyst_fsm #(
        .WIN_LEN (WIN_LEN),
        .HI_THR  (HI_THR),
        .LO_THR  (LO_THR)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .ones_cnt (ones_cnt),
        .level    (dout)
    );

endmodule

// File: tb/deglitch_window_tb.sv
module deglitch_window_tb;

    localparam int N  = 8;
    localparam int HI = 6;
    localparam int LO = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic smp_en = 1'b0;
    logic din = 1'b0;
    logic dout;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // reference model state
    bit hist [N];
    int mcnt = 0;
    bit mst = 1'b0;

    always #4 clk = ~clk;

    deglitch_window #(.WIN_LEN(N), .HI_THR(HI), .LO_THR(LO)) u_dut (
        .clk    (clk),
        .rst    (rst),
        .smp_en (smp_en),
        .din    (din),
        .dout   (dout)
    );

    // {16 samples applied LSB first, expected dout after one idle edge}
    localparam logic [16:0] VEC [9] = '{
        {16'hFFFF, 1'b1},
        {16'h0000, 1'b0},
        {16'h5555, 1'b0},
        {16'h00FF, 1'b0},
        {16'hFF00, 1'b1},
        {16'h0FFF, 1'b1},
        {16'hF000, 1'b0},
        {16'h0010, 1'b0},
        {16'hFFEF, 1'b1}
    };

    task automatic check(input bit act, input bit exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: dout=%0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input bit d, input bit e);
        din = d;
        smp_en = e;
        @(posedge clk);
        if (rst) begin
            for (int i = 0; i < N; i++) hist[i] = 1'b0;
            mcnt = 0;
            mst = 1'b0;
        end else begin
            if (!mst && mcnt > HI) mst = 1'b1;
            else if (mst && mcnt < LO) mst = 1'b0;
            if (e) begin
                mcnt = mcnt + int'(d) - int'(hist[N-1]);
                for (int i = N - 1; i > 0; i--) hist[i] = hist[i-1];
                hist[0] = d;
            end
        end
        @(negedge clk);
        check(dout, mst, "R2 R3 R4 R5 model");
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step(1'b0, 1'b0);
        step(1'b1, 1'b1);
        rst = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        check(dout, 1'b0, "R1 reset state");

        // table walk
        for (int v = 0; v < 9; v++) begin
            do_reset();
            for (int b = 0; b < 16; b++) step(VEC[v][b+1], 1'b1);
            step(1'b0, 1'b0);
            check(dout, VEC[v][0], $sformatf("R2 vector %0d", v));
        end

        // R6: strobe low while din toggles, window must stay empty
        do_reset();
        for (int i = 0; i < 20; i++) step(1'b1, 1'b0);
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1);
        check(dout, 1'b0, "R6 idle ones ignored");

        // R6: high state, strobe low with zeros, count must stay full
        do_reset();
        for (int i = 0; i < 10; i++) step(1'b1, 1'b1);
        for (int i = 0; i < 20; i++) step(1'b0, 1'b0);
        check(dout, 1'b1, "R6 idle zeros ignored");
        for (int i = 0; i < 6; i++) step(1'b0, 1'b1);
        step(1'b0, 1'b0);
        check(dout, 1'b1, "R4 R5 count equals LO holds");
        step(1'b0, 1'b1);
        step(1'b0, 1'b0);
        check(dout, 1'b0, "R4 count below LO falls");

        // R1 mid-run reset, then R3/R9 boundary from empty window
        for (int i = 0; i < 12; i++) step(1'b1, 1'b1);
        check(dout, 1'b1, "R3 high before reset");
        do_reset();
        check(dout, 1'b0, "R1 reset clears high");
        for (int i = 0; i < HI; i++) step(1'b1, 1'b1);
        step(1'b0, 1'b0);
        check(dout, 1'b0, "R9 R3 count equals HI stays low");
        step(1'b1, 1'b1);
        check(dout, 1'b0, "R3 one cycle latency");
        step(1'b0, 1'b0);
        check(dout, 1'b1, "R3 count above HI rises");

        // R7: long run of ones and zeros, count saturates at window size
        for (int i = 0; i < 40; i++) step(1'b1, 1'b1);
        for (int i = 0; i < 40; i++) step(1'b0, 1'b1);
        check(dout, 1'b0, "R7 R4 full swing");

        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule